// File: doc/BRIEF.md
# Smart Card Front-End Control Register Bus Slave

This block is a two-wire serial bus slave that holds the single 8-bit control register of a smart card interface front end. A fast system clock oversamples the bus clock and data lines, which may run at rates up to 400 kHz. The block finds START and STOP conditions, compares the address byte with its own address, and acknowledges when the address matches. A write transfer loads each data byte into the register. A read transfer returns the register value for as long as the master acknowledges.

The 7-bit device address is the fixed pattern `0100` followed by three strap inputs, so up to eight of these front ends can share one bus. The register drives the front end directly: bit 0 starts or stops the card session, bit 1 requests a warm reset, bit 2 selects the card supply (1 = 3 V), bit 3 stops the card clock, bit 4 sets the level the stopped clock rests at, bits 6:5 select the card clock divider and bit 7 enables the I/O path. Only the host can set the warm-reset bit. Hardware clears it when the card answers or is declared mute. The line is driven open-drain: the block raises an output enable whenever it pulls the line low, and it never drives the line high.

Top module: `cardif_i2c_ctrl`

## Requirements
- R1: The slave answers to the 7-bit address {4'b0100, addr_sel_i}. The address byte is therefore 40h + 2*addr_sel_i for a write and one more than that for a read, and bit 0 of the address byte is the read flag (1 = read).
- R2: After an address byte that does not match, the slave gives no acknowledge, does not drive the line, and leaves the register unchanged for every byte up to the next START.
- R3: After a matching address byte, and after each data byte the slave receives, the slave holds SDA low for the whole ninth SCL clock.
- R4: Each data byte of a write transfer is stored into ctrl_o. When a transfer carries several bytes, the register ends up holding the last byte.
- R5: A read transfer shifts out the register MSB first. The slave sends the value again after every byte the master acknowledges and stops driving after a NACK.
- R6: While rst_n is low, and after reset, ctrl_o is 00h and sda_oe_o is 0.
- R7: A one-cycle pulse on hw_clr_i clears ctrl_o bit 1 on the next clock and leaves the other bits unchanged.
- R8: A STOP at any point returns the slave to idle, and a repeated START begins a new address phase without a STOP before it.
- R9: The slave changes sda_oe_o only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | Open-drain enable; the pin is pulled low while this is 1 |
| addr_sel_i | input | 3 | Strap bits that form the low address bits |
| hw_clr_i | input | 1 | Card answered or declared mute; clears the warm-reset bit |
| ctrl_o | output | 8 | Control register contents |

## Verification
The bench sends address bytes for a neighbouring strap value and follows each with data bytes. A design that compares too few address bits would acknowledge these bytes or store the data. It also stops one transfer partway through the address byte. A design whose bit counter survives a STOP would then misalign the next address. It issues a repeated START between a write and a read-back, which catches a slave that recognises START only from idle. It also ends reads with a NACK after several acknowledged bytes. A slave that misreads the master's acknowledge would keep driving, corrupt the STOP, or stop too early. A watcher on the bus flags any change of the output enable while SCL is high, since such a change would show up on the bus as a false START or STOP.

// File: rtl/cardif_pkg.sv
package cardif_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WR,
        ST_WACK,
        ST_RD,
        ST_RACK
    } link_state_e;

    localparam int ADDR_BITS = 7;
    localparam logic [3:0] ADDR_FIXED = 4'b0100;
endpackage

// File: rtl/cardif_bus_sync.sv
module cardif_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[STAGES-2:0], sda_i};
        d.scl_prev = q.scl_pipe[STAGES-1];
        d.sda_prev = q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s     = q.scl_pipe[STAGES-1];
    assign sda_s     = q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~q.scl_prev;
    assign scl_fall  = ~scl_s & q.scl_prev;
    assign start_det = scl_s & q.scl_prev & q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & q.scl_prev & ~q.sda_prev & sda_s;
endmodule

// File: rtl/cardif_link_fsm.sv
module cardif_link_fsm
    import cardif_pkg::*;
#(
    parameter int W     = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [SEL_W-1:0] addr_sel,
    input  logic [W-1:0]     rd_data,
    output logic             wr_stb,
    output logic [W-1:0]     wr_data,
    output logic             sda_oe
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W);

    typedef struct packed {
        link_state_e     st;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]    sh;
        logic            rw;
        logic            nack;
        logic            oe;
        logic            stb;
    } link_t;

    link_t d, q;
    logic [ADDR_BITS-1:0] my_addr;

    assign my_addr = {ADDR_FIXED, addr_sel};

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_det) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == LAST) begin
                        if (q.sh[ADDR_BITS:1] == my_addr) begin
                            d.st = ST_AACK;
                            d.oe = 1'b1;
                            d.rw = q.sh[0];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.st = ST_RD;
                            d.sh = rd_data;
                            d.oe = ~rd_data[W-1];
                        end else begin
                            d.st = ST_WR;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == LAST) begin
                        d.stb = 1'b1;
                        d.st  = ST_WACK;
                        d.oe  = 1'b1;
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        d.st  = ST_WR;
                        d.oe  = 1'b0;
                        d.cnt = '0;
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.cnt == LAST) begin
                            d.st = ST_RACK;
                            d.oe = 1'b0;
                        end else begin
                            d.sh = {q.sh[W-2:0], 1'b0};
                            d.oe = ~q.sh[W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (!q.nack) begin
                            d.st  = ST_RD;
                            d.sh  = rd_data;
                            d.oe  = ~rd_data[W-1];
                            d.cnt = '0;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign wr_stb  = q.stb;
    assign wr_data = q.sh;
    assign sda_oe  = q.oe;
endmodule

// File: rtl/cardif_ctrl_reg.sv
module cardif_ctrl_reg #(
    parameter int W       = 8,
    parameter int CLR_BIT = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic [W-1:0] wr_data,
    input  logic         hw_clr,
    output logic [W-1:0] value
);
    logic [W-1:0] value_d, value_q;

    always_comb begin
        value_d = value_q;
        if (wr_stb) value_d = wr_data;
        if (hw_clr) value_d[CLR_BIT] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) value_q <= '0;
        else        value_q <= value_d;
    end

    assign value = value_q;
endmodule

// File: rtl/cardif_i2c_ctrl.sv
module cardif_i2c_ctrl #(
    parameter int W          = 8,
    parameter int SEL_W      = 3,
    parameter int SYNC_DEPTH = 2,
    parameter int WARM_BIT   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    input  logic [SEL_W-1:0] addr_sel_i,
    input  logic             hw_clr_i,
    output logic [W-1:0]     ctrl_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic wr_stb;
    logic [W-1:0] wr_data;

    cardif_bus_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cardif_link_fsm #(.W(W), .SEL_W(SEL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_sel  (addr_sel_i),
        .rd_data   (ctrl_o),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe_o)
    );

    cardif_ctrl_reg #(.W(W), .CLR_BIT(WARM_BIT)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .hw_clr  (hw_clr_i),
        .value   (ctrl_o)
    );
endmodule

// File: rtl/cardif_i2c_ctrl_chk.sv
module cardif_i2c_ctrl_chk #(
    parameter int W     = 8,
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_i,
    input logic             sda_oe_o,
    input logic [SEL_W-1:0] addr_sel_i,
    input logic             hw_clr_i,
    input logic [W-1:0]     ctrl_o
);
    // R6: register and line enable are cleared while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r6: assert (ctrl_o == '0 && !sda_oe_o);
        end
    end

    // R7: hardware clear leaves the warm-reset bit low on the next clock
    p_hw_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hw_clr_i |=> !ctrl_o[1]);

    // R9: the open-drain enable never moves while SCL is high
    p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    // R4: the register changes only by a bus write (SCL low) or a hardware clear
    p_ctrl_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ctrl_o) && !$past(hw_clr_i)) |-> !scl_i);
endmodule

bind cardif_i2c_ctrl cardif_i2c_ctrl_chk #(.W(W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/cardif_i2c_ctrl_tb.sv
module cardif_i2c_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [2:0] sel = 3'd0;
    logic       hw_clr = 1'b0;
    logic [7:0] ctrl;
    logic       sda_bus;

    int total = 0;
    int bad = 0;
    int oe_viol = 0;
    logic [7:0] model = 8'h00;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    cardif_i2c_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe),
        .addr_sel_i (sel),
        .hw_clr_i   (hw_clr),
        .ctrl_o     (ctrl)
    );

    // R9 bus watcher
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe !== oe_prev && scl_m) oe_viol++;
        oe_prev <= sda_oe;
    end

    function automatic logic [7:0] addr_byte(input logic [2:0] s, input logic rd);
        return {4'b0100, s, rd};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (5) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
    endtask

    task automatic bus_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
        end
    endtask

    // sends one byte; ack = 1 when SDA was low throughout the ninth clock (R3)
    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit lo1, lo2;
        bus_bits(b, 8);
        sda_m = 1'b1; qw(); scl_m = 1'b1;
        @(negedge clk); lo1 = !sda_bus;
        qw(); lo2 = !sda_bus;
        scl_m = 1'b0; qw();
        ack = lo1 && lo2;
    endtask

    task automatic recv_byte(input bit m_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw(); scl_m = 1'b1; qw(); b[i] = sda_bus; qw(); scl_m = 1'b0;
        end
        qw();
        sda_m = !m_ack; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] data[$], input string req);
        bit ack;
        bus_start();
        send_byte(addr_byte(sel, 1'b0), ack);
        chk(ack, "R1/R3 address ack", ack, 1);
        foreach (data[i]) begin
            send_byte(data[i], ack);
            chk(ack, "R3 data ack", ack, 1);
            model = data[i];
        end
        bus_stop();
        chk(ctrl == model, req, ctrl, model);
    endtask

    task automatic do_read(input int n);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte(addr_byte(sel, 1'b1), ack);
        chk(ack, "R1 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            chk(b == model, "R5 read data", b, model);
        end
        chk(!sda_oe, "R5 released after NACK", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        logic [7:0] q[$];
        logic [7:0] b;
        bit ack;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(ctrl == 8'h00 && !sda_oe, "R6 in reset", ctrl, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ctrl == 8'h00 && !sda_oe, "R6 after reset", ctrl, 0);

        // directed: every strap value answers its own address (R1)
        for (int s = 0; s < 8; s++) begin
            sel = 3'(s);
            q = '{8'(8'h11 * s + 1)};
            do_write(q, "R1 write per strap");
        end

        // directed: multi-byte write keeps last (R4)
        q = '{8'hA5, 8'h3C, 8'hF7};
        do_write(q, "R4 last byte kept");
        do_read(3);

        // directed: hardware clear of bit 1 (R7)
        @(negedge clk); hw_clr = 1'b1;
        @(negedge clk); hw_clr = 1'b0;
        model[1] = 1'b0;
        chk(ctrl == model, "R7 hw clear", ctrl, model);

        // directed: STOP in the middle of an address byte, then a full write (R8)
        bus_start();
        bus_bits(addr_byte(sel, 1'b0), 4);
        sda_m = 1'b0; qw();
        bus_stop();
        q = '{8'h5A};
        do_write(q, "R8 write after aborted address");

        // directed: repeated START between write and read-back (R8)
        bus_start();
        send_byte(addr_byte(sel, 1'b0), ack);
        chk(ack, "R8 address ack", ack, 1);
        send_byte(8'hC3, ack);
        model = 8'hC3;
        bus_start();
        send_byte(addr_byte(sel, 1'b1), ack);
        chk(ack, "R8 ack after repeated start", ack, 1);
        recv_byte(1'b0, b);
        chk(b == 8'hC3, "R8 read after repeated start", b, 8'hC3);
        bus_stop();

        // constrained random mix
        for (int it = 0; it < 30; it++) begin
            int kind;
            sel  = 3'($urandom_range(0, 7));
            kind = $urandom_range(0, 3);
            if (kind <= 1) begin
                q = {};
                for (int k = 0; k < $urandom_range(1, 3); k++) q.push_back(8'($urandom));
                do_write(q, "R4 random write");
            end else if (kind == 2) begin
                logic [2:0] other;
                other = sel ^ 3'($urandom_range(1, 7));
                bus_start();
                send_byte(addr_byte(other, 1'b0), ack);
                chk(!ack, "R2 no ack on mismatch", ack, 0);
                send_byte(8'($urandom), ack);
                chk(!ack, "R2 data ignored", ack, 0);
                bus_stop();
                chk(ctrl == model, "R2 register unchanged", ctrl, model);
            end else begin
                do_read($urandom_range(1, 3));
            end
        end

        chk(oe_viol == 0, "R9 oe moved with SCL high", oe_viol, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule